// File: doc/BRIEF.md
# Thirty-Two Bit Flag-Producing ALU

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. A 4-bit operation code picks one of sixteen fixed operations on two operands, `opa` and `opb`. The operations are two pass-through moves, a bitwise inverse, increment, decrement, negation, add and subtract each with and without the incoming carry, three one-bit right shifts, and exclusive-or, or and and. Every result settles in one pass through the logic, with no state.

Alongside the 32-bit result the unit produces four status bits: carry, signed overflow, negative and zero. A surrounding pipeline owns the flag register. It supplies the current carry as `carry_in` and decides whether the result and flags are kept. For every subtracting operation, the carry output reports a borrow.

Top module: `flag_alu`

## Requirements
- R1: Codes 0000 and 1111 give result = opa with carry_out = 0 and ovf_out = 0.
- R2: Code 1110 gives result = ~opa with carry_out = 0 and ovf_out = 0.
- R3: Code 0001 gives opa+1, with carry_out set only when opa = 0xFFFFFFFF and ovf_out set only when opa = 0x7FFFFFFF. Code 0101 gives opa-1, with carry_out (borrow) set only when opa = 0 and ovf_out set only when opa = 0x80000000.
- R4: Code 0100 gives 0-opa, with carry_out (borrow) set when opa is nonzero and ovf_out set only when opa = 0x80000000.
- R5: Code 0011 gives opb+opa and code 0010 gives opa+opb+carry_in. carry_out is the unsigned carry out of bit 31, and ovf_out is set when the true signed sum lies outside the 32-bit two's-complement range.
- R6: Code 0111 gives opb-opa and code 0110 gives opb-opa-carry_in. carry_out is set when the unsigned subtrahend exceeds opb (a borrow), and ovf_out is set when the true signed difference lies outside the 32-bit range.
- R7: Code 1000 gives {carry_in, opa[31:1]} with carry_out = opa[0] and ovf_out = 0.
- R8: Code 1001 gives {opa[31], opa[31:1]} and code 1010 gives {0, opa[31:1]}. Both give carry_out = opa[0] and ovf_out = 0.
- R9: Codes 1011, 1100 and 1101 give opb XOR opa, opb OR opa and opb AND opa, each with carry_out = 0 and ovf_out = 0.
- R10: neg_out equals result bit 31, and zero_out is 1 exactly when all 32 result bits are 0, for every code.
- R11: For every code other than 0010, 0110 and 1000, carry_in has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| carry_in | input | 1 | Current carry flag from the surrounding flag register |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry, or borrow for subtracting operations, or bit shifted out |
| ovf_out | output | 1 | Signed two's-complement overflow |
| neg_out | output | 1 | Result bit 31 |
| zero_out | output | 1 | Result is all zeros |

## Verification
The unit has no state, so a wrong decode or a misrouted carry shows at the ports in the same evaluation as the stimulus. It appears as a result or flag that differs from the reference for that one vector. Corner operands are the likely place for such an error to hide, so the bench applies them for every code: zero, all ones, and the two signed extremes. For each of those, swapping carry_in shows whether an operation that should ignore the carry is sensitive to it. Each stimulus is applied on one clock edge and compared at the following falling edge.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int ALU_W = 32;

    typedef enum logic [3:0] {
        OP_MOVE = 4'b0000,
        OP_INC  = 4'b0001,
        OP_ADC  = 4'b0010,
        OP_ADD  = 4'b0011,
        OP_NEG  = 4'b0100,
        OP_DEC  = 4'b0101,
        OP_SBB  = 4'b0110,
        OP_SUB  = 4'b0111,
        OP_RRC  = 4'b1000,
        OP_ASR  = 4'b1001,
        OP_LSR  = 4'b1010,
        OP_XOR  = 4'b1011,
        OP_OR   = 4'b1100,
        OP_AND  = 4'b1101,
        OP_NOT  = 4'b1110,
        OP_PASS = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_SHIFT = 2'd1,
        CLS_LOGIC = 2'd2
    } alu_cls_e;

    // Adder input selection
    typedef enum logic [1:0] { XS_A = 2'd0, XS_B = 2'd1, XS_ZERO = 2'd2 } xsel_e;
    typedef enum logic [1:0] { YS_B = 2'd0, YS_NOTA = 2'd1, YS_ZERO = 2'd2, YS_MINUS2 = 2'd3 } ysel_e;
    typedef enum logic [1:0] { CS_ZERO = 2'd0, CS_ONE = 2'd1, CS_CIN = 2'd2, CS_NCIN = 2'd3 } csel_e;

    typedef struct packed {
        xsel_e xsel;
        ysel_e ysel;
        csel_e csel;
        logic  borrow;
    } add_ctrl_t;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } alu_flags_t;

    function automatic alu_cls_e op_class(alu_op_e op);
        case (op)
            OP_INC, OP_ADC, OP_ADD, OP_NEG,
            OP_DEC, OP_SBB, OP_SUB:          return CLS_ARITH;
            OP_RRC, OP_ASR, OP_LSR:          return CLS_SHIFT;
            default:                         return CLS_LOGIC;
        endcase
    endfunction

    function automatic add_ctrl_t add_decode(alu_op_e op);
        add_ctrl_t k;
        k = '{xsel: XS_A, ysel: YS_ZERO, csel: CS_ZERO, borrow: 1'b0};
        case (op)
            OP_INC: k = '{xsel: XS_A,    ysel: YS_ZERO,   csel: CS_ONE,  borrow: 1'b0};
            OP_ADC: k = '{xsel: XS_A,    ysel: YS_B,      csel: CS_CIN,  borrow: 1'b0};
            OP_ADD: k = '{xsel: XS_A,    ysel: YS_B,      csel: CS_ZERO, borrow: 1'b0};
            OP_NEG: k = '{xsel: XS_ZERO, ysel: YS_NOTA,   csel: CS_ONE,  borrow: 1'b1};
            OP_DEC: k = '{xsel: XS_A,    ysel: YS_MINUS2, csel: CS_ONE,  borrow: 1'b1};
            OP_SBB: k = '{xsel: XS_B,    ysel: YS_NOTA,   csel: CS_NCIN, borrow: 1'b1};
            OP_SUB: k = '{xsel: XS_B,    ysel: YS_NOTA,   csel: CS_ONE,  borrow: 1'b1};
            default: ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
    import flag_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  add_ctrl_t      ctrl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   sum,
    output logic           cflag,
    output logic           vflag
);
    localparam int LW = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;
    logic [LW:0]  low;
    logic         c_into_msb;
    logic         c_out_raw;

    always_comb begin
        case (ctrl.xsel)
            XS_A:    x = a;
            XS_B:    x = b;
            default: x = '0;
        endcase
        case (ctrl.ysel)
            YS_B:      y = b;
            YS_NOTA:   y = ~a;
            YS_MINUS2: y = {{(W-1){1'b1}}, 1'b0};
            default:   y = '0;
        endcase
        case (ctrl.csel)
            CS_ONE:  ci = 1'b1;
            CS_CIN:  ci = cin;
            CS_NCIN: ci = ~cin;
            default: ci = 1'b0;
        endcase
    end

    // Split at the sign bit so the carry into it is visible for overflow
    always_comb begin
        low        = {1'b0, x[LW-1:0]} + {1'b0, y[LW-1:0]} + {{LW{1'b0}}, ci};
        c_into_msb = low[LW];
        sum        = {x[W-1] ^ y[W-1] ^ c_into_msb, low[LW-1:0]};
        c_out_raw  = (x[W-1] & y[W-1]) | (c_into_msb & (x[W-1] ^ y[W-1]));
        vflag      = c_into_msb ^ c_out_raw;
        cflag      = ctrl.borrow ? ~c_out_raw : c_out_raw;
    end

    always_comb begin
        // R5
        add_total_chk: assert ({c_out_raw, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}));
        // R6
        sign_ovf_chk: assert (!vflag || ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1])));
    end

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter
    import flag_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    logic fill;

    always_comb begin
        case (op)
            OP_RRC:  fill = cin;
            OP_ASR:  fill = a[W-1];
            default: fill = 1'b0;
        endcase
        res  = {fill, a[W-1:1]};
        cout = a[0];
    end

    always_comb begin
        // R8
        shift_body_chk: assert (res[W-2:0] == (a >> 1));
        // R7
        rrc_top_chk: assert (op != OP_RRC || res[W-1] == cin);
    end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    always_comb begin
        case (op)
            OP_XOR:  res = b ^ a;
            OP_OR:   res = b | a;
            OP_AND:  res = b & a;
            OP_NOT:  res = ~a;
            default: res = a;
        endcase
    end

    always_comb begin
        // R9
        and_subset_chk: assert (op != OP_AND || (res & ~(a | b)) == '0);
        // R2
        not_inv_chk: assert (op != OP_NOT || (res ^ a) == '1);
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [3:0]     op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic           carry_in,
    output logic [W-1:0]   result,
    output logic           carry_out,
    output logic           ovf_out,
    output logic           neg_out,
    output logic           zero_out
);
    alu_op_e    op_e;
    alu_cls_e   cls;
    add_ctrl_t  actrl;
    logic [W-1:0] add_res, sh_res, lg_res;
    logic       add_c, add_v, sh_c;
    alu_flags_t fl;

    assign op_e  = alu_op_e'(op);
    assign cls   = op_class(op_e);
    assign actrl = add_decode(op_e);

    flag_alu_adder #(.W(W)) u_add (
        .ctrl (actrl),
        .a    (opa),
        .b    (opb),
        .cin  (carry_in),
        .sum  (add_res),
        .cflag(add_c),
        .vflag(add_v)
    );

    flag_alu_shifter #(.W(W)) u_shift (
        .op  (op_e),
        .a   (opa),
        .cin (carry_in),
        .res (sh_res),
        .cout(sh_c)
    );

    flag_alu_logic #(.W(W)) u_logic (
        .op (op_e),
        .a  (opa),
        .b  (opb),
        .res(lg_res)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: begin
                result = add_res;
                fl.c   = add_c;
                fl.v   = add_v;
            end
            CLS_SHIFT: begin
                result = sh_res;
                fl.c   = sh_c;
                fl.v   = 1'b0;
            end
            default: begin
                result = lg_res;
                fl.c   = 1'b0;
                fl.v   = 1'b0;
            end
        endcase
        fl.n = result[W-1];
        fl.z = (result == '0);
    end

    assign carry_out = fl.c;
    assign ovf_out   = fl.v;
    assign neg_out   = fl.n;
    assign zero_out  = fl.z;

    always_comb begin
        // R1
        move_pass_chk: assert (!(op_e == OP_MOVE || op_e == OP_PASS) || result == opa);
        // R9
        logic_flags_chk: assert (cls != CLS_LOGIC || (!carry_out && !ovf_out));
        // R8
        shift_no_ovf_chk: assert (cls != CLS_SHIFT || (!ovf_out && carry_out == opa[0]));
        // R10
        zero_not_neg_chk: assert (!zero_out || !neg_out);
    end

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out, ovf_out, neg_out, zero_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu dut (
        .op(op), .opa(opa), .opb(opb), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .ovf_out(ovf_out),
        .neg_out(neg_out), .zero_out(zero_out)
    );

    // Behavioural reference: returns {c, v, n, z, result}
    function automatic logic [35:0] ref_alu(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic ci);
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint uci = ci ? 64'd1 : 64'd0;
        longint full = 0;
        longint s = 0;
        logic [31:0] r = '0;
        logic c = 1'b0, v = 1'b0, arith = 1'b0;
        case (o)
            4'd1: begin full = ua + 1; s = sa + 1; arith = 1; c = full > 64'hFFFF_FFFF; end
            4'd2: begin full = ua + ub + uci; s = sa + sb + uci; arith = 1; c = full > 64'hFFFF_FFFF; end
            4'd3: begin full = ua + ub; s = sa + sb; arith = 1; c = full > 64'hFFFF_FFFF; end
            4'd4: begin full = -ua; s = -sa; arith = 1; c = (ua != 0); end
            4'd5: begin full = ua - 1; s = sa - 1; arith = 1; c = (ua == 0); end
            4'd6: begin full = ub - ua - uci; s = sb - sa - uci; arith = 1; c = (ub < ua + uci); end
            4'd7: begin full = ub - ua; s = sb - sa; arith = 1; c = (ub < ua); end
            4'd8: begin r = {ci, a[31:1]}; c = a[0]; end
            4'd9: begin r = {a[31], a[31:1]}; c = a[0]; end
            4'd10: begin r = {1'b0, a[31:1]}; c = a[0]; end
            4'd11: r = b ^ a;
            4'd12: r = b | a;
            4'd13: r = b & a;
            4'd14: r = ~a;
            default: r = a;
        endcase
        if (arith) begin
            r = full[31:0];
            v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        return {c, v, r[31], (r == 32'd0), r};
    endfunction

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'd0, 4'd15: return "R1";
            4'd14: return "R2";
            4'd1, 4'd5: return "R3";
            4'd4: return "R4";
            4'd2, 4'd3: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9, 4'd10: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b, input logic ci, input string tag);
        logic [35:0] exp;
        @(posedge clk);
        op = o; opa = a; opb = b; carry_in = ci;
        @(negedge clk);
        exp = ref_alu(o, a, b, ci);
        n_checks++;
        if ({carry_out, ovf_out, result} !== {exp[35], exp[34], exp[31:0]}) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h ci=%b: got c=%b v=%b r=%h expected c=%b v=%b r=%h",
                     tag, o, a, b, ci, carry_out, ovf_out, result, exp[35], exp[34], exp[31:0]);
        end
        n_checks++;
        if ({neg_out, zero_out} !== exp[33:32]) begin
            n_fail++;
            $display("FAIL R10 op=%b a=%h b=%h: got n=%b z=%b expected n=%b z=%b",
                     o, a, b, neg_out, zero_out, exp[33], exp[32]);
        end
    endtask

    // R11: outputs must match between the two carry_in values
    task automatic cin_blind(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        logic [35:0] got0;
        apply(o, a, b, 1'b0, "R11");
        got0 = {carry_out, ovf_out, neg_out, zero_out, result};
        apply(o, a, b, 1'b1, "R11");
        n_checks++;
        if ({carry_out, ovf_out, neg_out, zero_out, result} !== got0) begin
            n_fail++;
            $display("FAIL R11 op=%b: got %h with carry_in=1 expected %h", o,
                     {carry_out, ovf_out, neg_out, zero_out, result}, got0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] corners [6];
        logic [31:0] lf;
        corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'h0000_0001; corners[5] = 32'hA5A5_5A5B;

        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero inputs, move code, result zero with zero flag
        @(negedge clk);
        n_checks++;
        if (result !== 32'd0 || zero_out !== 1'b1 || carry_out !== 1'b0 || ovf_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle: got r=%h z=%b expected r=0 z=1", result, zero_out);
        end

        // Directed boundary cases
        apply(4'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, "R3");
        apply(4'd1, 32'h7FFF_FFFF, 32'd0, 1'b0, "R3");
        apply(4'd5, 32'h0000_0000, 32'd0, 1'b0, "R3");
        apply(4'd5, 32'h8000_0000, 32'd0, 1'b0, "R3");
        apply(4'd4, 32'h8000_0000, 32'd0, 1'b0, "R4");
        apply(4'd4, 32'h0000_0000, 32'd0, 1'b0, "R4");
        apply(4'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R5");
        apply(4'd3, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R5");
        apply(4'd6, 32'h0000_0000, 32'h0000_0000, 1'b1, "R6");
        apply(4'd6, 32'h0000_0001, 32'h8000_0001, 1'b1, "R6");
        apply(4'd7, 32'h0000_0001, 32'h8000_0000, 1'b0, "R6");
        apply(4'd8, 32'h0000_0001, 32'd0, 1'b1, "R7");
        apply(4'd8, 32'h8000_0000, 32'd0, 1'b0, "R7");
        apply(4'd9, 32'h8000_0001, 32'd0, 1'b0, "R8");
        apply(4'd10, 32'h8000_0001, 32'd0, 1'b1, "R8");
        apply(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R1");
        apply(4'd15, 32'h1234_5678, 32'd0, 1'b1, "R1");
        apply(4'd14, 32'hFFFF_FFFF, 32'd0, 1'b1, "R2");
        apply(4'd13, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, "R9");

        // Every code against every corner pair, both carry values
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        apply(4'(o), corners[i], corners[j], 1'(c), tag_of(4'(o)));

        // Carry-insensitive codes
        for (int o = 0; o < 16; o++)
            if (o != 2 && o != 6 && o != 8)
                for (int i = 0; i < 6; i++)
                    cin_blind(4'(o), corners[i], corners[5 - i]);

        // Pseudo-random sweep
        lf = 32'hACE1_1234;
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] ra, rb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ra = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rb = lf ^ 32'h5555_0000;
            apply(lf[3:0], ra, rb, lf[7], tag_of(lf[3:0]));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule